// File: doc/BRIEF.md
# Periodic Split-Transaction Microframe Scheduler

This block works out what a host controller should do with one periodic interrupt queue head in each high-speed microframe. It looks at the queue head's endpoint-speed field and its two microframe masks. One mask selects the microframes for start-splits and the other selects the microframes for complete-splits. It also reads the frame number and microframe number from the frame timer. On every microframe tick it reports exactly one decision: start-split, complete-split or idle. Alongside that decision it gives the endpoint-type code that goes into the split token.

Software budgets the timing of the full/low-speed pipeline, so the block honours the masks exactly as written. It never retries and never defers. It remembers the split that is in flight. A start-split placed late in a frame can leave complete-splits that land in the early microframes of the following frame, and the block issues those after the frame number advances. Complete-splits that miss their microframe are discarded.

Top module: `split_uframe_sched`

## Requirements
- R1: Split actions happen only while the speed field is 00 (full-speed) or 01 (low-speed) and the start-split mask is non-zero. Speed 10 (high-speed) never yields a split action, whatever the masks hold.
- R2: On a tick at microframe n whose start-split mask bit n is set, the action code one clock later is 01 (start-split).
- R3: A complete-split (code 10) is issued at microframe n only if complete mask bit n is set and a start-split is in progress. In the start's own frame, n must be above the start microframe. Complete bits seen before any start yield no action.
- R4: The token endpoint-type output is 11 (interrupt) whenever the action is a start-split or a complete-split, and 00 when the action is idle.
- R5: A start-split at microframe 4 or later sets the wrap-pending flag when complete mask bits exist below the start microframe. Those complete-splits are issued in the next frame at their own microframes. The flag clears after the last of them is issued.
- R6: Complete-splits that miss their microframe are not made up. If the frame number moves past the start frame plus one while a split is pending, the pending work and the wrap-pending flag are dropped.
- R7: When both masks select the same microframe, that microframe issues the start-split, and the configuration-error output is high one clock after the overlapping masks are presented.
- R8: Each tick produces exactly one action strobe, one clock after the tick. The strobe is low in cycles that follow no tick. Action codes are 00 idle, 01 start-split and 10 complete-split.
- R9: A synchronous reset clears the strobe, the error flag, the wrap-pending flag and any split in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse marking the start of a microframe |
| frame_idx | input | FRAME_W | Current frame number from the frame timer |
| uframe_idx | input | UF_W | Current microframe number within the frame |
| ep_speed | input | 2 | Endpoint speed: 00 full, 01 low, 10 high |
| smask | input | UF_PER_FRAME | Start-split microframe mask, bit n for microframe n |
| cmask | input | UF_PER_FRAME | Complete-split microframe mask, bit n for microframe n |
| act_valid | output | 1 | Action strobe, one per tick |
| act_code | output | 2 | Action: 00 idle, 01 start-split, 10 complete-split |
| tok_ep_type | output | 2 | Endpoint-type code for the split token |
| cfg_err | output | 1 | Start and complete masks overlap |
| wrap_pend | output | 1 | Complete-splits are carried into the next frame |

## Verification
The bench drives whole frames of ticks with several mask patterns. A start early in the frame followed by complete-splits checks plain in-frame scheduling. A late start whose complete mask bits lie below it shows whether carried-over complete-splits appear after the frame number changes and whether complete bits before any start stay silent. High-speed and empty-start-mask patterns separate the enable gating from the mask decoding. Overlapping masks confirm start priority and the error flag. A jump of two frames and a reset in the middle of a wrap confirm that pending work is dropped rather than caught up.

// File: rtl/split_uframe_sched.sv
`timescale 1ns/1ps
module split_uframe_sched #(
  parameter int UF_PER_FRAME = 8,
  parameter int FRAME_W      = 11,
  parameter int LATE_UF      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [FRAME_W-1:0]      frame_idx,
  input  logic [$clog2(UF_PER_FRAME)-1:0] uframe_idx,
  input  logic [1:0]              ep_speed,
  input  logic [UF_PER_FRAME-1:0] smask,
  input  logic [UF_PER_FRAME-1:0] cmask,
  output logic                    act_valid,
  output logic [1:0]              act_code,
  output logic [1:0]              tok_ep_type,
  output logic                    cfg_err,
  output logic                    wrap_pend
);
  localparam int UF_W = $clog2(UF_PER_FRAME);
  localparam logic [1:0] SPD_FULL = 2'b00;
  localparam logic [1:0] SPD_LOW  = 2'b01;
  localparam logic [1:0] ACT_IDLE = 2'b00;
  localparam logic [1:0] ACT_SS   = 2'b01;
  localparam logic [1:0] ACT_CS   = 2'b10;
  localparam logic [1:0] EPT_INTR = 2'b11;

  logic               busy;
  logic [UF_W-1:0]    sp;
  logic [FRAME_W-1:0] sf;
  logic [UF_PER_FRAME-1:0] above_u, below_u, below_sp;

  always_comb begin
    for (int i = 0; i < UF_PER_FRAME; i++) begin
      above_u[i]  = i > int'(uframe_idx);
      below_u[i]  = i < int'(uframe_idx);
      below_sp[i] = i < int'(sp);
    end
  end

  wire split_en   = (ep_speed == SPD_FULL || ep_speed == SPD_LOW) && |smask;
  wire same_frame = frame_idx == sf;
  wire next_frame = frame_idx == FRAME_W'(sf + 1'b1);
  wire [UF_PER_FRAME-1:0] wrap_bits = cmask & below_sp;

  wire do_start = split_en && smask[uframe_idx];
  wire in_cs    = busy && same_frame && (uframe_idx > sp) && cmask[uframe_idx];
  wire wrap_cs  = busy && wrap_pend && next_frame && (uframe_idx < sp) && cmask[uframe_idx];
  wire do_cs    = split_en && !do_start && (in_cs || wrap_cs);
  wire rem_in   = |(cmask & above_u) || wrap_pend;
  wire rem_wrap = |(wrap_bits & above_u);
  wire stale    = busy && !(same_frame || (wrap_pend && next_frame && uframe_idx < sp));
  wire new_wrap = (int'(uframe_idx) >= LATE_UF) && |(cmask & below_u);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid   <= 1'b0;
      act_code    <= ACT_IDLE;
      tok_ep_type <= 2'b00;
      cfg_err     <= 1'b0;
      wrap_pend   <= 1'b0;
      busy        <= 1'b0;
      sp          <= '0;
      sf          <= '0;
    end else begin
      cfg_err     <= split_en && |(smask & cmask);
      act_valid   <= tick;
      act_code    <= ACT_IDLE;
      tok_ep_type <= 2'b00;
      if (tick) begin
        if (!split_en) begin
          busy      <= 1'b0;
          wrap_pend <= 1'b0;
        end else if (do_start) begin
          act_code    <= ACT_SS;
          tok_ep_type <= EPT_INTR;
          sp          <= uframe_idx;
          sf          <= frame_idx;
          wrap_pend   <= new_wrap;
          busy        <= |(cmask & above_u) || new_wrap;
        end else if (do_cs) begin
          act_code    <= ACT_CS;
          tok_ep_type <= EPT_INTR;
          if (wrap_cs) begin
            busy      <= rem_wrap;
            wrap_pend <= rem_wrap;
          end else begin
            busy      <= rem_in;
          end
        end else if (stale) begin
          busy      <= 1'b0;
          wrap_pend <= 1'b0;
        end
      end
    end
  end

  AST_SPLIT_GATED: assert property (@(posedge clk) disable iff (rst)
    (act_code != ACT_IDLE) |-> $past(split_en)); // R1
  AST_START_ON_MASK: assert property (@(posedge clk) disable iff (rst)
    (act_code == ACT_SS) |-> $past(smask[uframe_idx])); // R2
  AST_CS_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    (act_code == ACT_CS) |-> $past(busy && cmask[uframe_idx])); // R3
  AST_WRAP_ONLY_LATE: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_pend) |-> (int'($past(uframe_idx)) >= LATE_UF)); // R5
  AST_ERR_ON_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(|(smask & cmask))); // R7
  AST_STROBE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> $past(tick)); // R8
endmodule

// File: tb/sim_split_uframe_sched.sv
`timescale 1ns/1ps
module sim_split_uframe_sched;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [10:0] frame_idx = '0;
  logic [2:0]  uframe_idx = '0;
  logic [1:0]  ep_speed = 2'b00;
  logic [7:0]  smask = '0, cmask = '0;
  logic act_valid, cfg_err, wrap_pend;
  logic [1:0] act_code, tok_ep_type;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_uframe_sched u0 (
    .clk(clk), .rst(rst), .tick(tick), .frame_idx(frame_idx), .uframe_idx(uframe_idx),
    .ep_speed(ep_speed), .smask(smask), .cmask(cmask), .act_valid(act_valid),
    .act_code(act_code), .tok_ep_type(tok_ep_type), .cfg_err(cfg_err), .wrap_pend(wrap_pend));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic tick_uf(input string req, input int fr, input int uf, input logic [1:0] exp);
    @(negedge clk);
    frame_idx = 11'(fr); uframe_idx = 3'(uf); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R8", "strobe after tick", int'(act_valid), 1);
    check(req, $sformatf("action f%0d u%0d", fr, uf), int'(act_code), int'(exp));
    check("R4", "token type", int'(tok_ep_type), (exp == 2'b00) ? 0 : 3);
    @(negedge clk);
    check("R8", "no strobe without tick", int'(act_valid), 0);
  endtask

  task automatic run_frame(input string req, input int fr, input logic [15:0] exp);
    for (int u = 0; u < 8; u++) tick_uf(req, fr, u, exp[2*u +: 2]);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9", "reset strobe", int'(act_valid), 0);
    check("R9", "reset wrap", int'(wrap_pend), 0);
    check("R9", "reset err", int'(cfg_err), 0);
  endtask

  task automatic t_normal();
    do_reset();
    ep_speed = 2'b00; smask = 8'h02; cmask = 8'h1C;
    run_frame("R2/R3", 5, 16'h02A4);
    check("R7", "no error without overlap", int'(cfg_err), 0);
    check("R5", "no wrap for early start", int'(wrap_pend), 0);
  endtask

  task automatic t_gating();
    do_reset();
    ep_speed = 2'b10; smask = 8'h02; cmask = 8'h1C;
    run_frame("R1", 7, 16'h0000);
    ep_speed = 2'b01; smask = 8'h00;
    run_frame("R1", 8, 16'h0000);
  endtask

  task automatic t_wrap();
    do_reset();
    ep_speed = 2'b01; smask = 8'h20; cmask = 8'h83;
    for (int u = 0; u < 5; u++) tick_uf("R3", 9, u, 2'b00);
    tick_uf("R2", 9, 5, 2'b01);
    check("R5", "wrap set after late start", int'(wrap_pend), 1);
    tick_uf("R3", 9, 6, 2'b00);
    tick_uf("R3", 9, 7, 2'b10);
    tick_uf("R5", 10, 0, 2'b10);
    check("R5", "wrap held mid carry", int'(wrap_pend), 1);
    tick_uf("R5", 10, 1, 2'b10);
    check("R5", "wrap cleared after last carry", int'(wrap_pend), 0);
    for (int u = 2; u < 5; u++) tick_uf("R5", 10, u, 2'b00);
    tick_uf("R2", 10, 5, 2'b01);
    check("R5", "wrap set again", int'(wrap_pend), 1);
    tick_uf("R6", 12, 0, 2'b00);
    check("R6", "wrap dropped on skipped frame", int'(wrap_pend), 0);
    tick_uf("R6", 12, 1, 2'b00);
  endtask

  task automatic t_conflict();
    do_reset();
    ep_speed = 2'b00; smask = 8'h04; cmask = 8'h0C;
    @(negedge clk);
    check("R7", "overlap error", int'(cfg_err), 1);
    run_frame("R7", 3, 16'h0090);
  endtask

  task automatic t_reset_mid();
    do_reset();
    ep_speed = 2'b01; smask = 8'h20; cmask = 8'h83;
    tick_uf("R2", 30, 5, 2'b01);
    check("R5", "wrap before reset", int'(wrap_pend), 1);
    do_reset();
    check("R9", "wrap cleared by reset", int'(wrap_pend), 0);
    tick_uf("R9", 31, 0, 2'b00);
  endtask

  initial begin
    t_reset_state();
    t_normal();
    t_gating();
    t_wrap();
    t_conflict();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule